// File: doc/BRIEF.md
# Bus Access Break Comparator

This block watches every bus access the processor makes and raises a break request when the access meets a programmed condition. The condition is built from an address, an address-space identifier, an access-size selector and an optional masked data value. The number of low address bits left out of the address compare depends on the access size. This lets one programmed address catch any access that falls inside the aligned unit of that size.

When data comparison is on, a 64-bit access is split into two 32-bit words, and the access matches if either word matches. Byte and word accesses compare only their low lanes. Operand accesses that carry no data are never flagged. Instruction fetches are matched without looking at the data.

The break request is registered. It is high for one clock cycle, in the cycle after the clock edge that samples the matching access.

Top module: `brk_cmp_top`

## Requirements
- R1: With size selector 3'b100 (quadword), only address bits 31..3 are compared, so a quadword access matches anywhere inside the aligned 8-byte unit.
- R2: Size selector 3'b011 (longword) compares address bits 31..2, 3'b010 (word) compares bits 31..1, and 3'b001 (byte) compares all 32 bits.
- R3: With size selector 3'b000 the access size is not part of the condition, and the compared address bits follow the access's own size code, using the R1/R2 mapping. With a nonzero selector the access size code must equal the selector.
- R4: When the identifier enable is 1, the 8-bit access identifier must equal the programmed identifier. When the enable is 0, the identifier has no effect.
- R5: When data compare is enabled, a break needs the address, identifier and data conditions all at once. A data mask bit of 1 leaves that data bit out of the compare, and a mask bit of 0 requires the bits to be equal.
- R6: For a quadword access (size 3'b100) with data compare enabled, access data bits 31..0 and bits 63..32 are each compared with the 32-bit value. A hit in either half is enough.
- R7: For word accesses only data, value and mask bits 15..0 are compared, and for byte accesses only bits 7..0. Value and mask bits 31..16 are ignored for both.
- R8: When data compare is enabled, an operand access with has-data low never raises a break.
- R9: For an instruction fetch (fetch flag 1), the data condition, the data value and the has-data flag have no effect.
- R10: The break output goes high for exactly one cycle, in the cycle after the rising edge that samples a matching access. It is low while reset is asserted and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | An access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 3 | Access size code (001 byte, 010 word, 011 long, 100 quad) |
| acc_asid | input | 8 | Access address-space identifier |
| acc_is_ifetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| acc_has_data | input | 1 | Access carries data |
| acc_data | input | 64 | Access data, low lanes first |
| cfg_addr | input | 32 | Programmed break address |
| cfg_asid | input | 8 | Programmed identifier |
| cfg_asid_en | input | 1 | Include the identifier in the condition |
| cfg_size | input | 3 | Size selector (000 = any size) |
| cfg_data_en | input | 1 | Include data in the condition |
| cfg_data | input | 32 | Programmed data value |
| cfg_mask | input | 32 | Data mask, 1 = don't care |
| brk_o | output | 1 | Registered one-cycle break request |

## Verification
The address compare is driven with accesses offset from the programmed address by an amount just inside and just outside each size's aligned unit. This tells the width of the ignored low bits apart from an exact compare. With selector 000, the same address is tried with different access sizes, which shows whether the access's own size sets the compare width. Quadword data is placed in the low half only, the high half only, and neither half, so the either-half rule is kept distinct from a low-half-only compare. Word and byte data carry garbage in the upper lanes, and the config carries garbage in its upper bits, to show that those lanes are ignored. Data-less operands and fetches with mismatching data check the two exclusion rules.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic [2:0] {
        SZ_ANY  = 3'b000,
        SZ_BYTE = 3'b001,
        SZ_WORD = 3'b010,
        SZ_LONG = 3'b011,
        SZ_QUAD = 3'b100
    } size_e;

    // Number of low address bits dropped from the compare for a size code.
    function automatic logic [1:0] ign_bits(input logic [2:0] sz);
        case (sz)
            SZ_QUAD: ign_bits = 2'd3;
            SZ_LONG: ign_bits = 2'd2;
            SZ_WORD: ign_bits = 2'd1;
            default: ign_bits = 2'd0;
        endcase
    endfunction

    typedef struct packed {
        logic brk;
    } brk_state_t;
endpackage

// File: rtl/brk_addr_match.sv
module brk_addr_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [2:0]        eff_size,
    output logic              hit
);
    logic [ADDR_W-1:0] care;
    logic [1:0]        nign;

    always_comb begin
        nign = ign_bits(eff_size);
        care = '1 << nign;
        hit  = ((acc_addr ^ cfg_addr) & care) == '0;
    end
endmodule

// File: rtl/brk_lane_cmp.sv
module brk_lane_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] lane,
    input  logic [W-1:0] value,
    input  logic [W-1:0] dont_care,
    output logic         hit
);
    always_comb hit = ((lane ^ value) & ~dont_care) == '0;
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_vld,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [2:0]              acc_size,
    input  logic [ID_W-1:0]         acc_asid,
    input  logic                    acc_is_ifetch,
    input  logic                    acc_has_data,
    input  logic [LANES*DATA_W-1:0] acc_data,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [ID_W-1:0]         cfg_asid,
    input  logic                    cfg_asid_en,
    input  logic [2:0]              cfg_size,
    input  logic                    cfg_data_en,
    input  logic [DATA_W-1:0]       cfg_data,
    input  logic [DATA_W-1:0]       cfg_mask,
    output logic                    brk_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;

    logic [2:0]        eff_size;
    logic              size_ok;
    logic              addr_hit;
    logic [DATA_W-1:0] width_dc;
    logic [DATA_W-1:0] lane_dc;
    logic [LANES-1:0]  lane_hit;
    logic              data_hit;
    logic              data_ok;
    logic              asid_ok;
    brk_state_t        st_d, st_q;

    always_comb begin
        eff_size = (cfg_size == SZ_ANY) ? acc_size : cfg_size;
        size_ok  = (cfg_size == SZ_ANY) || (acc_size == cfg_size);
    end

    brk_addr_match #(.ADDR_W(ADDR_W)) u_addr (
        .acc_addr (acc_addr),
        .cfg_addr (cfg_addr),
        .eff_size (eff_size),
        .hit      (addr_hit)
    );

    // Lanes above the access width are forced to don't-care.
    always_comb begin
        case (eff_size)
            SZ_BYTE: width_dc = {{(DATA_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};
            SZ_WORD: width_dc = {{(DATA_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};
            default: width_dc = '0;
        endcase
        lane_dc = cfg_mask | width_dc;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        brk_lane_cmp #(.W(DATA_W)) u_lane (
            .lane      (acc_data[g*DATA_W +: DATA_W]),
            .value     (cfg_data),
            .dont_care (lane_dc),
            .hit       (lane_hit[g])
        );
    end

    always_comb begin
        if (eff_size == SZ_QUAD) data_hit = |lane_hit;
        else                     data_hit = lane_hit[0];
        data_ok = !cfg_data_en || acc_is_ifetch || (acc_has_data && data_hit);
        asid_ok = !cfg_asid_en || (acc_asid == cfg_asid);
    end

    always_comb begin
        st_d     = st_q;
        st_d.brk = acc_vld && size_ok && addr_hit && asid_ok && data_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_o = st_q.brk;
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_vld,
    input logic [31:0] acc_addr,
    input logic [2:0]  acc_size,
    input logic [7:0]  acc_asid,
    input logic        acc_is_ifetch,
    input logic        acc_has_data,
    input logic [31:0] cfg_addr,
    input logic [7:0]  cfg_asid,
    input logic        cfg_asid_en,
    input logic [2:0]  cfg_size,
    input logic        cfg_data_en,
    input logic        brk_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> !brk_o); // R10

    AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> !brk_o); // R10

    AST_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[31:3] != cfg_addr[31:3]) |=> !brk_o); // R1

    AST_SIZE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size != 3'b000 && acc_size != cfg_size) |=> !brk_o); // R3

    AST_ID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_asid_en && acc_asid != cfg_asid) |=> !brk_o); // R4

    AST_NO_DATA_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data_en && !acc_is_ifetch && !acc_has_data) |=> !brk_o); // R8

    AST_FETCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_is_ifetch && acc_addr == cfg_addr
         && (cfg_size == 3'b000 || acc_size == cfg_size)
         && (!cfg_asid_en || acc_asid == cfg_asid)) |=> brk_o); // R9
endmodule

bind brk_cmp_top brk_cmp_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_vld       (acc_vld),
    .acc_addr      (acc_addr),
    .acc_size      (acc_size),
    .acc_asid      (acc_asid),
    .acc_is_ifetch (acc_is_ifetch),
    .acc_has_data  (acc_has_data),
    .cfg_addr      (cfg_addr),
    .cfg_asid      (cfg_asid),
    .cfg_asid_en   (cfg_asid_en),
    .cfg_size      (cfg_size),
    .cfg_data_en   (cfg_data_en),
    .brk_o         (brk_o)
);

// File: tb/brk_cmp_top_bench.sv
module brk_cmp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_size = '0;
    logic [7:0]  acc_asid = '0;
    logic        acc_is_ifetch = 1'b0;
    logic        acc_has_data = 1'b0;
    logic [63:0] acc_data = '0;
    logic [31:0] cfg_addr = 32'h8000_1230;
    logic [7:0]  cfg_asid = 8'h5A;
    logic        cfg_asid_en = 1'b0;
    logic [2:0]  cfg_size = '0;
    logic        cfg_data_en = 1'b0;
    logic [31:0] cfg_data = '0;
    logic [31:0] cfg_mask = '0;
    logic        brk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brk_cmp_top u_brk_cmp_top (.*);

    typedef struct packed {
        logic [2:0]  csz;
        logic        aen;
        logic        den;
        logic [31:0] cdat;
        logic [31:0] cmsk;
        logic [2:0]  asz;
        logic [31:0] aaddr;
        logic        idok;
        logic        ifet;
        logic        hd;
        logic [63:0] adat;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{3'd4,1'b0,1'b0,32'h0,32'h0,3'd4,32'h8000_1237,1'b1,1'b0,1'b1,64'h0,1'b1,8'd1},          // R1 inside unit
        '{3'd4,1'b0,1'b0,32'h0,32'h0,3'd4,32'h8000_1238,1'b1,1'b0,1'b1,64'h0,1'b0,8'd1},          // R1 bit 3 differs
        '{3'd3,1'b0,1'b0,32'h0,32'h0,3'd3,32'h8000_1233,1'b1,1'b0,1'b1,64'h0,1'b1,8'd2},          // R2 long inside
        '{3'd3,1'b0,1'b0,32'h0,32'h0,3'd3,32'h8000_1234,1'b1,1'b0,1'b1,64'h0,1'b0,8'd2},          // R2 long outside
        '{3'd2,1'b0,1'b0,32'h0,32'h0,3'd2,32'h8000_1231,1'b1,1'b0,1'b1,64'h0,1'b1,8'd2},          // R2 word inside
        '{3'd1,1'b0,1'b0,32'h0,32'h0,3'd1,32'h8000_1231,1'b1,1'b0,1'b1,64'h0,1'b0,8'd2},          // R2 byte exact
        '{3'd0,1'b0,1'b0,32'h0,32'h0,3'd3,32'h8000_1232,1'b1,1'b0,1'b1,64'h0,1'b1,8'd3},          // R3 any, long
        '{3'd0,1'b0,1'b0,32'h0,32'h0,3'd1,32'h8000_1232,1'b1,1'b0,1'b1,64'h0,1'b0,8'd3},          // R3 any, byte
        '{3'd3,1'b0,1'b0,32'h0,32'h0,3'd2,32'h8000_1230,1'b1,1'b0,1'b1,64'h0,1'b0,8'd3},          // R3 size mismatch
        '{3'd3,1'b1,1'b0,32'h0,32'h0,3'd3,32'h8000_1230,1'b0,1'b0,1'b1,64'h0,1'b0,8'd4},          // R4 id wrong
        '{3'd3,1'b0,1'b0,32'h0,32'h0,3'd3,32'h8000_1230,1'b0,1'b0,1'b1,64'h0,1'b1,8'd4},          // R4 id off
        '{3'd3,1'b1,1'b1,32'hDEAD_BEEF,32'h0,3'd3,32'h8000_1230,1'b1,1'b0,1'b1,64'h0000_0000_DEAD_BEEF,1'b1,8'd5}, // R5 all match
        '{3'd3,1'b1,1'b1,32'hDEAD_BEEF,32'h0,3'd3,32'h8000_1230,1'b1,1'b0,1'b1,64'h0000_0000_DEAD_BEEE,1'b0,8'd5}, // R5 one bit
        '{3'd3,1'b0,1'b1,32'hDEAD_BE00,32'h0000_00FF,3'd3,32'h8000_1230,1'b1,1'b0,1'b1,64'h0000_0000_DEAD_BE77,1'b1,8'd5}, // R5 masked
        '{3'd4,1'b0,1'b1,32'hDEAD_BEEF,32'h0,3'd4,32'h8000_1230,1'b1,1'b0,1'b1,64'h1111_2222_DEAD_BEEF,1'b1,8'd6}, // R6 low half
        '{3'd4,1'b0,1'b1,32'hDEAD_BEEF,32'h0,3'd4,32'h8000_1230,1'b1,1'b0,1'b1,64'hDEAD_BEEF_1111_2222,1'b1,8'd6}, // R6 high half
        '{3'd4,1'b0,1'b1,32'hDEAD_BEEF,32'h0,3'd4,32'h8000_1230,1'b1,1'b0,1'b1,64'hDEAD_BEEE_1111_2222,1'b0,8'd6}, // R6 neither
        '{3'd2,1'b0,1'b1,32'hABCD_1234,32'h5A5A_0000,3'd2,32'h8000_1230,1'b1,1'b0,1'b1,64'hFFFF_FFFF_5555_1234,1'b1,8'd7}, // R7 word
        '{3'd1,1'b0,1'b1,32'h1234_5656,32'h0,3'd1,32'h8000_1230,1'b1,1'b0,1'b1,64'hFFFF_FFFF_5555_AA56,1'b1,8'd7}, // R7 byte
        '{3'd3,1'b0,1'b1,32'hDEAD_BEEF,32'h0,3'd3,32'h8000_1230,1'b1,1'b0,1'b0,64'h0000_0000_DEAD_BEEF,1'b0,8'd8}, // R8 no data
        '{3'd3,1'b0,1'b1,32'hDEAD_BEEF,32'h0,3'd3,32'h8000_1230,1'b1,1'b1,1'b0,64'h0,1'b1,8'd9}   // R9 fetch
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: brk_o=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_size      = v.csz;
        cfg_asid_en   = v.aen;
        cfg_data_en   = v.den;
        cfg_data      = v.cdat;
        cfg_mask      = v.cmsk;
        acc_size      = v.asz;
        acc_addr      = v.aaddr;
        acc_asid      = v.idok ? cfg_asid : 8'hA5;
        acc_is_ifetch = v.ifet;
        acc_has_data  = v.hd;
        acc_data      = v.adat;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(brk_o, 1'b0, "R10 reset state");
        // Matching access while reset is held: output stays low.
        apply(VECS[0]);
        acc_vld = 1'b1;
        @(negedge clk);
        check(brk_o, 1'b0, "R10 low during reset");
        acc_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(brk_o, 1'b0, "R10 after reset");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            acc_vld = 1'b1;
            @(negedge clk);
            acc_vld = 1'b0;
            check(brk_o, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
            @(negedge clk);
        end

        // R10: single pulse, then low again.
        apply(VECS[0]);
        acc_vld = 1'b1;
        @(negedge clk);
        acc_vld = 1'b0;
        check(brk_o, 1'b1, "R10 pulse high");
        @(negedge clk);
        check(brk_o, 1'b0, "R10 pulse ends");

        // R10: back-to-back hits give back-to-back pulses.
        acc_vld = 1'b1;
        @(negedge clk);
        check(brk_o, 1'b1, "R10 back-to-back first");
        @(negedge clk);
        acc_vld = 1'b0;
        check(brk_o, 1'b1, "R10 back-to-back second");
        @(negedge clk);
        check(brk_o, 1'b0, "R10 back-to-back end");

        // R9: fetch with data compare on, no data, and a mismatching value.
        apply(VECS[20]);
        acc_data = 64'h0123_4567_0000_0000;
        acc_vld = 1'b1;
        @(negedge clk);
        acc_vld = 1'b0;
        check(brk_o, 1'b1, "R9 fetch ignores mismatching data");

        // R8: the same operand access with data present does hit.
        apply(VECS[19]);
        acc_has_data = 1'b1;
        acc_vld = 1'b1;
        @(negedge clk);
        acc_vld = 1'b0;
        check(brk_o, 1'b1, "R8 operand with data hits");
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule